// File: doc/BRIEF.md
# Interval-Timer Host Register Front End

This block sits between a byte-wide host bus and a three-channel interval timer. The host reaches the timer through two address bits. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is a shared control port that only accepts writes. A control word carries a channel-select field in bits 7..6. The remaining six bits hold an access-format code (bits 5..4), a counting-mode code (bits 3..1) and a decimal-counting flag (bit 0). The block routes the mode and the flag to the chosen channel and keeps that channel's access format. The counting datapath is outside this block: it takes the mode, the flag and committed reload values, and it returns live 16-bit counts.

Each channel turns byte writes into a 16-bit reload value and turns its 16-bit count into byte reads. The access format decides how this works. Format 1 moves only the low byte and format 2 moves only the high byte; in both cases the other byte of a reload is zero. Format 3 moves the low byte and then the high byte. It has a write toggle and a separate read toggle, and each one walks through two states, `BYTE_LO` then `BYTE_HI`.

Access code 0 is a latch command. It copies the live count into a holding register, and reads return that copy until the access sequence is complete. While the latch is held, the channel is in the held state. The transitions are:
- capture: a latch command while free.
- release: the last byte of the sequence is read.
- drop: a new control word is written.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset every channel has mode 0, decimal flag 0, access format 3 (low then high) and reload value 0. Both toggles are at `BYTE_LO`, no latch is held, and no strobe is active.
- R2: A control write with select 0..2 and access code 1..3 stores bits 3..1 as the mode and bit 0 as the decimal flag of that channel. It also pulses that channel's `cfg_stb` for the one cycle after the write. The other channels do not change.
- R3: A control word with select value 3 is ignored. No configuration, strobe or reload output changes.
- R4: In format 3, the first data write holds its byte as the low half and raises no strobe. The second data write commits {second, first} to `reload_out` with a one-cycle `reload_stb`.
- R5: In format 1, each data write commits {00h, byte}. In format 2, each data write commits {byte, 00h}. Both give a one-cycle `reload_stb`.
- R6: A control write (access code 1..3) returns the channel's write toggle and read toggle to `BYTE_LO`. After it, the next format-3 write is taken as the low byte.
- R7: A latch command (access code 0) captures the live count in the cycle of the command, and it does not change the format or the configuration. Reads then return bytes of the held value, whatever the live count does. The latch releases after the final byte of the sequence is read: the high byte in format 3, or the single byte in formats 1 and 2.
- R8: A latch command on a channel that already holds a latch has no effect. The held value is kept.
- R9: Without a latch, a read returns a byte of the live count: the low byte in format 1 and the high byte in format 2. In format 3 reads alternate between low and high, starting with low.
- R10: The read toggle and the write toggle of a channel are independent. A read between the two bytes of a format-3 write does not disturb the pending write.
- R11: `rdata` is 00h unless `cs` and `rd` are high and the address is 0..2. A read of address 3 returns 00h. Strobes with `cs` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one cycle per byte read |
| wr | input | 1 | Write strobe, one cycle per byte written |
| addr | input | 2 | 0..2 data port of a channel, 3 control port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational during a read |
| count_in | input | 48 | Live counts, channel i in bits 16i+15..16i |
| mode_out | output | 9 | Mode per channel, channel i in bits 3i+2..3i |
| bcd_out | output | 3 | Decimal-counting flag per channel |
| cfg_stb | output | 3 | One-cycle pulse after a configuration write |
| reload_out | output | 48 | Committed reload value per channel |
| reload_stb | output | 3 | One-cycle pulse when a reload value is committed |

## Verification
The assertions assume that `rd` and `wr` are never high in the same cycle. They also assume that each strobe lasts one clock per byte, because every cycle with a strobe counts as one access. The stimulus drives exactly one access per cycle pair, each with a single-cycle strobe, and never raises both strobes together. Live counts change only between accesses, so the value a latch captures is well defined.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                ctrl_wr,
    input  logic [7:0]          word,
    output logic [NCH-1:0]      cfg_en,
    output logic [NCH-1:0]      latch_en,
    output logic [1:0]          acc,
    output logic [MODE_W-1:0]   mode,
    output logic                bcd
);

    logic [1:0] sel_f;

    assign sel_f = word[7:6];
    assign acc   = word[5:4];
    assign mode  = word[3:1];
    assign bcd   = word[0];

    for (genvar g = 0; g < NCH; g++) begin : g_en
        logic hit;
        assign hit         = ctrl_wr && (sel_f == 2'(g));
        assign cfg_en[g]   = hit && (acc != 2'd0);
        assign latch_en[g] = hit && (acc == 2'd0);
    end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                latch_en,
    input  logic [1:0]          acc_in,
    input  logic [MODE_W-1:0]   mode_in,
    input  logic                bcd_in,
    input  logic                data_wr,
    input  logic                data_rd,
    input  logic [BW-1:0]       wdata,
    input  logic [2*BW-1:0]     count,
    output logic [MODE_W-1:0]   mode_q,
    output logic                bcd_q,
    output logic                cfg_stb,
    output logic [2*BW-1:0]     reload_q,
    output logic                reload_stb,
    output logic [BW-1:0]       rbyte
);

    localparam int CW = 2 * BW;

    acc_e          fmt_q,  fmt_d;
    byte_e         wtog_q, wtog_d;
    byte_e         rtog_q, rtog_d;
    logic          lat_q,  lat_d;
    logic [CW-1:0] hold_q, hold_d;
    logic [BW-1:0] lo_q,   lo_d;
    logic          commit;
    logic [CW-1:0] commit_val;
    logic [CW-1:0] src;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= ACC_LOHI;
            wtog_q <= BYTE_LO;
            rtog_q <= BYTE_LO;
            lat_q  <= 1'b0;
            hold_q <= '0;
            lo_q   <= '0;
        end else begin
            fmt_q  <= fmt_d;
            wtog_q <= wtog_d;
            rtog_q <= rtog_d;
            lat_q  <= lat_d;
            hold_q <= hold_d;
            lo_q   <= lo_d;
        end
    end

    // next state
    always_comb begin
        fmt_d      = fmt_q;
        wtog_d     = wtog_q;
        rtog_d     = rtog_q;
        lat_d      = lat_q;
        hold_d     = hold_q;
        lo_d       = lo_q;
        commit     = 1'b0;
        commit_val = '0;

        if (cfg_en) begin
            fmt_d  = acc_e'(acc_in);
            wtog_d = BYTE_LO;
            rtog_d = BYTE_LO;
            lat_d  = 1'b0;
        end else if (latch_en && !lat_q) begin
            lat_d  = 1'b1;
            hold_d = count;
        end

        if (data_wr) begin
            unique case (fmt_q)
                ACC_LO: begin
                    commit     = 1'b1;
                    commit_val = {{BW{1'b0}}, wdata};
                end
                ACC_HI: begin
                    commit     = 1'b1;
                    commit_val = {wdata, {BW{1'b0}}};
                end
                ACC_LOHI: begin
                    if (wtog_q == BYTE_LO) begin
                        lo_d   = wdata;
                        wtog_d = BYTE_HI;
                    end else begin
                        commit     = 1'b1;
                        commit_val = {wdata, lo_q};
                        wtog_d     = BYTE_LO;
                    end
                end
                default: ;
            endcase
        end

        if (data_rd) begin
            if (fmt_q == ACC_LOHI) begin
                if (rtog_q == BYTE_LO) begin
                    rtog_d = BYTE_HI;
                end else begin
                    rtog_d = BYTE_LO;
                    lat_d  = 1'b0;
                end
            end else begin
                lat_d = 1'b0;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            bcd_q      <= 1'b0;
            cfg_stb    <= 1'b0;
            reload_q   <= '0;
            reload_stb <= 1'b0;
        end else begin
            cfg_stb    <= cfg_en;
            reload_stb <= commit;
            if (cfg_en) begin
                mode_q <= mode_in;
                bcd_q  <= bcd_in;
            end
            if (commit) begin
                reload_q <= commit_val;
            end
        end
    end

    assign src = lat_q ? hold_q : count;

    always_comb begin
        unique case (fmt_q)
            ACC_HI:   rbyte = src[CW-1:BW];
            ACC_LOHI: rbyte = (rtog_q == BYTE_LO) ? src[BW-1:0] : src[CW-1:BW];
            default:  rbyte = src[BW-1:0];
        endcase
    end

    // R2
    cfg_stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb |-> $past(cfg_en));

    // R4
    lohi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_stb && $past(fmt_q) == ACC_LOHI) |-> $past(wtog_q) == BYTE_HI);

    // R6
    cfg_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_en) |-> (wtog_q == BYTE_LO && rtog_q == BYTE_LO));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && $past(lat_q)) |-> $stable(hold_q));

endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int BW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs,
    input  logic                     rd,
    input  logic                     wr,
    input  logic [1:0]               addr,
    input  logic [BW-1:0]            wdata,
    output logic [BW-1:0]            rdata,
    input  logic [NCH*2*BW-1:0]      count_in,
    output logic [NCH*MODE_W-1:0]    mode_out,
    output logic [NCH-1:0]           bcd_out,
    output logic [NCH-1:0]           cfg_stb,
    output logic [NCH*2*BW-1:0]      reload_out,
    output logic [NCH-1:0]           reload_stb
);

    localparam int         CW     = 2 * BW;
    localparam logic [1:0] CTRL_A = 2'(NCH);

    logic                ctrl_wr;
    logic [NCH-1:0]      cfg_en, latch_en;
    logic [1:0]          acc;
    logic [MODE_W-1:0]   mode;
    logic                bcd;
    logic [BW-1:0]       rbyte [NCH];

    assign ctrl_wr = cs && wr && (addr == CTRL_A);

    tmr_ctrl_decode #(.NCH(NCH)) i_dec (
        .ctrl_wr  (ctrl_wr),
        .word     (wdata[7:0]),
        .cfg_en   (cfg_en),
        .latch_en (latch_en),
        .acc      (acc),
        .mode     (mode),
        .bcd      (bcd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = cs && (addr == 2'(g));

        tmr_chan_port #(.BW(BW)) i_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_en     (cfg_en[g]),
            .latch_en   (latch_en[g]),
            .acc_in     (acc),
            .mode_in    (mode),
            .bcd_in     (bcd),
            .data_wr    (hit && wr),
            .data_rd    (hit && rd),
            .wdata      (wdata),
            .count      (count_in[g*CW +: CW]),
            .mode_q     (mode_out[g*MODE_W +: MODE_W]),
            .bcd_q      (bcd_out[g]),
            .cfg_stb    (cfg_stb[g]),
            .reload_q   (reload_out[g*CW +: CW]),
            .reload_stb (reload_stb[g]),
            .rbyte      (rbyte[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cs && rd && addr == 2'(i)) rdata = rbyte[i];
        end
    end

    // R2
    cfg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_stb));

    // R3
    reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == CTRL_A && wdata[7:6] == 2'b11) |=> cfg_stb == '0);

    // R11
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs) |=> (reload_stb == '0 && cfg_stb == '0));

endmodule

// File: tb/test_tmr_host_regs.sv
module test_tmr_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] count_in = '0;
    logic [8:0]  mode_out;
    logic [2:0]  bcd_out, cfg_stb, reload_stb;
    logic [47:0] reload_out;

    always #4 clk = ~clk;

    tmr_host_regs i_tmr_host_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .count_in(count_in), .mode_out(mode_out),
        .bcd_out(bcd_out), .cfg_stb(cfg_stb), .reload_out(reload_out),
        .reload_stb(reload_stb)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model
    int          m_fmt [3];
    int          m_mode[3];
    int          m_bcd [3];
    int          m_wtog[3];
    int          m_rtog[3];
    int          m_lat [3];
    logic [15:0] m_hold[3];
    logic [7:0]  m_lo  [3];
    logic [15:0] m_rel [3];
    logic [2:0]  e_cstb, e_rstb;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cnt(input int c);
        return count_in[c*16 +: 16];
    endfunction

    task automatic m_reset();
        for (int c = 0; c < 3; c++) begin
            m_fmt[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wtog[c] = 0;
            m_rtog[c] = 0; m_lat[c] = 0; m_hold[c] = 0; m_lo[c] = 0; m_rel[c] = 0;
        end
        e_cstb = 0; e_rstb = 0;
    endtask

    task automatic m_write(input logic c_s, input logic [1:0] a, input logic [7:0] d);
        int s, ac;
        e_cstb = 0; e_rstb = 0;
        if (!c_s) return;
        if (a == 2'd3) begin
            s = d[7:6]; ac = d[5:4];
            if (s == 3) return;
            if (ac == 0) begin
                if (m_lat[s] == 0) begin m_lat[s] = 1; m_hold[s] = cnt(s); end
            end else begin
                m_fmt[s] = ac; m_mode[s] = d[3:1]; m_bcd[s] = d[0];
                m_wtog[s] = 0; m_rtog[s] = 0; m_lat[s] = 0; e_cstb[s] = 1'b1;
            end
        end else begin
            s = a;
            case (m_fmt[s])
                1: begin m_rel[s] = {8'h00, d}; e_rstb[s] = 1'b1; end
                2: begin m_rel[s] = {d, 8'h00}; e_rstb[s] = 1'b1; end
                default: begin
                    if (m_wtog[s] == 0) begin m_lo[s] = d; m_wtog[s] = 1; end
                    else begin m_rel[s] = {d, m_lo[s]}; m_wtog[s] = 0; e_rstb[s] = 1'b1; end
                end
            endcase
        end
    endtask

    function automatic logic [7:0] m_read(input logic c_s, input logic [1:0] a);
        logic [15:0] src;
        int s;
        if (!c_s || a == 2'd3) return 8'h00;
        s = a;
        src = m_lat[s] ? m_hold[s] : cnt(s);
        case (m_fmt[s])
            1: begin m_lat[s] = 0; return src[7:0]; end
            2: begin m_lat[s] = 0; return src[15:8]; end
            default: begin
                if (m_rtog[s] == 0) begin m_rtog[s] = 1; return src[7:0]; end
                m_rtog[s] = 0; m_lat[s] = 0; return src[15:8];
            end
        endcase
    endfunction

    task automatic check_outs(input string tag);
        for (int c = 0; c < 3; c++) begin
            chk(tag, 32'(cfg_stb[c]), 32'(e_cstb[c]));
            chk(tag, 32'(reload_stb[c]), 32'(e_rstb[c]));
            chk(tag, 32'(mode_out[c*3 +: 3]), 32'(m_mode[c]));
            chk(tag, 32'(bcd_out[c]), 32'(m_bcd[c]));
            chk(tag, 32'(reload_out[c*16 +: 16]), 32'(m_rel[c]));
        end
    endtask

    task automatic wr_op(input logic c_s, input logic [1:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        cs = c_s; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
        m_write(c_s, a, d);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        check_outs(tag);
    endtask

    task automatic rd_op(input logic c_s, input logic [1:0] a, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        cs = c_s; rd = 1'b1; wr = 1'b0; addr = a;
        #1;
        exp = m_read(c_s, a);
        chk(tag, 32'(rdata), 32'(exp));
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        e_cstb = 0; e_rstb = 0;
        check_outs(tag);
    endtask

    task automatic set_cnt(input int c, input logic [15:0] v);
        @(negedge clk);
        count_in[c*16 +: 16] = v;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outs("R1");
        chk("R1", 32'(rdata), 32'h0);

        // R2 configuration of each channel
        wr_op(1, 3, 8'h36, "R2");
        chk("R2", 32'(mode_out[2:0]), 32'd3);
        wr_op(1, 3, 8'h76, "R2");
        wr_op(1, 3, 8'hB6, "R2");
        wr_op(1, 3, 8'h1B, "R2");
        chk("R2", 32'(bcd_out[0]), 32'd1);
        // R3 reserved select
        wr_op(1, 3, 8'hC5, "R3");
        wr_op(1, 3, 8'hFF, "R3");
        // R4 low then high on channel 1
        wr_op(1, 1, 8'hA0, "R4");
        chk("R4", 32'(reload_stb), 32'h0);
        wr_op(1, 1, 8'h01, "R4");
        chk("R4", 32'(reload_out[31:16]), 32'h01A0);
        // R5 single-byte formats
        wr_op(1, 0, 8'h0D, "R5");
        chk("R5", 32'(reload_out[15:0]), 32'h000D);
        wr_op(1, 3, 8'hA4, "R5");
        wr_op(1, 2, 8'h7E, "R5");
        chk("R5", 32'(reload_out[47:32]), 32'h7E00);
        // R6 toggle reset by control word
        wr_op(1, 1, 8'h11, "R6");
        wr_op(1, 3, 8'h76, "R6");
        wr_op(1, 1, 8'h22, "R6");
        wr_op(1, 1, 8'h33, "R6");
        chk("R6", 32'(reload_out[31:16]), 32'h3322);
        // R7 / R8 latch
        set_cnt(1, 16'h1234);
        wr_op(1, 3, 8'h40, "R7");
        set_cnt(1, 16'h5678);
        rd_op(1, 1, "R7");
        set_cnt(1, 16'h9999);
        wr_op(1, 3, 8'h40, "R8");
        rd_op(1, 1, "R8");
        rd_op(1, 1, "R7");
        rd_op(1, 1, "R9");
        // R7 latch released after the single byte in format 2
        set_cnt(2, 16'hBEEF);
        wr_op(1, 3, 8'h80, "R7");
        set_cnt(2, 16'h0102);
        rd_op(1, 2, "R7");
        rd_op(1, 2, "R9");
        // R10 interleaved read during a pending write
        wr_op(1, 1, 8'h44, "R10");
        rd_op(1, 1, "R10");
        wr_op(1, 1, 8'h55, "R10");
        chk("R10", 32'(reload_out[31:16]), 32'h5544);
        rd_op(1, 1, "R10");
        // R11 idle and control-port reads
        rd_op(1, 3, "R11");
        rd_op(0, 1, "R11");
        wr_op(0, 1, 8'h99, "R11");
        wr_op(0, 3, 8'h16, "R11");

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            int op;
            op = $urandom % 8;
            if (op < 2) begin
                wr_op(($urandom % 8) != 0, 3, 8'($urandom), "R2");
            end else if (op < 5) begin
                wr_op(($urandom % 8) != 0, 2'($urandom % 3), 8'($urandom), "R4");
            end else if (op < 7) begin
                rd_op(($urandom % 8) != 0, 2'($urandom), "R9");
            end else begin
                set_cnt($urandom % 3, 16'($urandom));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule